// File: doc/BRIEF.md
# Value-Checked Transaction Commit Unit

This block settles optimistic transactions for one memory partition. Each request brings two logs. The read log lists the words the transaction saw, as address and value pairs. The write log lists the words it wants to store, also as address and value pairs. The unit holds a small word memory that stands for the partition. It decides commit or abort by checking the recorded values again against that memory, so it keeps no record of who owns a word. A committed transaction stores its write log. An aborted one leaves memory as it was.

Requests enter a queue of in-flight slots in arrival order. At entry, a transaction's read log is checked speculatively against memory as it stands. In the same cycle it is compared with the write sets of every older transaction still in the queue. A transaction that reads a word an older queued transaction may write is marked as waiting. Transactions that share no words with older ones keep their speculative result. The head of the queue is finalized one per cycle. A waiting transaction is checked again against current memory when it reaches the head. Outcomes, with the transaction's tag, leave on a valid/ready response channel in arrival order.

Top module: `tcu_commit_unit`

## Requirements
- R1: After reset no response is pending, `req_ready` is 1, and every memory word reads as zero.
- R2: A transaction commits (`resp_commit`=1) exactly when each of its active read entries holds the current memory value at its address, with all earlier transactions already applied in arrival order. Otherwise it aborts (`resp_commit`=0).
- R3: A commit writes every active write entry into memory. An abort changes no memory word.
- R4: If two active write entries of one transaction name the same address, the entry with the higher index wins.
- R5: Entry i of a log (address bits [i*AW +: AW], data bits [i*DW +: DW]) is active when i is below the log's count. A count above the entry limit means the limit. A read count of zero always passes validation.
- R6: Responses come out in arrival order, and each carries the tag given with its request.
- R7: A transaction that reads an address in the write set of an older, not yet finalized transaction is checked again against memory after that older transaction is finalized. Its outcome then reflects whether the older one committed or aborted.
- R8: Up to NSLOT transactions wait for finalization. With NSLOT held, `req_ready` is 0 until one is finalized.
- R9: While `resp_valid` is 1 and `resp_ready` is 0, the response tag and outcome stay unchanged.
- R10: When the queue is empty and the response register is free, the response appears on the clock edge after the edge that accepted the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | A free slot can take the request |
| req_tag | input | TW | Transaction tag echoed in the response |
| req_rd_cnt | input | $clog2(NRD+1) | Number of active read entries |
| req_rd_addr | input | NRD*AW | Read entry addresses, entry i at [i*AW +: AW] |
| req_rd_data | input | NRD*DW | Values seen by the reads, entry i at [i*DW +: DW] |
| req_wr_cnt | input | $clog2(NWR+1) | Number of active write entries |
| req_wr_addr | input | NWR*AW | Write entry addresses |
| req_wr_data | input | NWR*DW | Write entry values |
| resp_valid | output | 1 | Outcome present |
| resp_ready | input | 1 | Consumer takes the outcome |
| resp_tag | output | TW | Tag of the finalized transaction |
| resp_commit | output | 1 | 1 = committed, 0 = aborted |

## Verification
The bench builds stalled-reader chains by holding `resp_ready` low. A reader then sits behind an older writer of the same word, in two variants: the older writer commits, or it aborts. A unit that trusted its speculative check would commit readers it should abort, and abort readers that the older write made correct. Further directed cases target repeated write addresses, counts above the entry limit, entries past the count, and an abort whose write log must leave no trace. Getting these wrong shows up as a changed word when a later transaction reads it back. The bench also fills every slot to check back-pressure, holds a response to check its stability, and runs a random stream over a few hot addresses. Every outcome in that stream is compared with a serial model.

// File: rtl/tcu_pkg.sv
`timescale 1ns/1ps
package tcu_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE    = 2'd0,
    SLOT_CLEAR   = 2'd1,
    SLOT_STALLED = 2'd2
  } slot_state_t;

  // Active entry count: a request count above the entry limit means the limit.
  function automatic int clamp_count(input int cnt, input int maxv);
    return (cnt > maxv) ? maxv : cnt;
  endfunction
endpackage

// File: rtl/tcu_log_check.sv
`timescale 1ns/1ps
module tcu_log_check import tcu_pkg::*; #(
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int NENT = 4,
  parameter int CW   = 3
) (
  input  logic [CW-1:0]          cnt,
  input  logic [NENT*AW-1:0]     addr,
  input  logic [NENT*DW-1:0]     data,
  input  logic [(1<<AW)*DW-1:0]  mem_flat,
  output logic                   all_match
);
  logic [NENT-1:0] entry_ok;

  generate
    for (genvar i = 0; i < NENT; i++) begin : g_ent
      logic [AW-1:0] a;
      logic [DW-1:0] seen;
      logic [DW-1:0] cur;
      assign a    = addr[i*AW +: AW];
      assign seen = data[i*DW +: DW];
      assign cur  = mem_flat[int'(a)*DW +: DW];
      assign entry_ok[i] = (i >= clamp_count(int'(cnt), NENT)) || (cur == seen);
    end
  endgenerate

  assign all_match = &entry_ok;
endmodule

// File: rtl/tcu_hazard.sv
`timescale 1ns/1ps
module tcu_hazard import tcu_pkg::*; #(
  parameter int AW    = 4,
  parameter int NRD   = 4,
  parameter int NWR   = 4,
  parameter int NSLOT = 4,
  parameter int RCW   = 3,
  parameter int WCW   = 3
) (
  input  logic [RCW-1:0]          rd_cnt,
  input  logic [NRD*AW-1:0]       rd_addr,
  input  logic [NSLOT-1:0]        slot_busy,
  input  logic [NSLOT*WCW-1:0]    slot_wcnt,
  input  logic [NSLOT*NWR*AW-1:0] slot_waddr,
  output logic                    hit
);
  always_comb begin
    int nr;
    hit = 1'b0;
    nr  = clamp_count(int'(rd_cnt), NRD);
    for (int s = 0; s < NSLOT; s++) begin
      for (int r = 0; r < NRD; r++) begin
        for (int w = 0; w < NWR; w++) begin
          if (slot_busy[s] && (r < nr) &&
              (w < clamp_count(int'(slot_wcnt[s*WCW +: WCW]), NWR)) &&
              (rd_addr[r*AW +: AW] == slot_waddr[(s*NWR + w)*AW +: AW]))
            hit = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tcu_word_mem.sv
`timescale 1ns/1ps
module tcu_word_mem import tcu_pkg::*; #(
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int NWR = 4,
  parameter int WCW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [WCW-1:0]        wr_cnt,
  input  logic [NWR*AW-1:0]     wr_addr,
  input  logic [NWR*DW-1:0]     wr_data,
  output logic [(1<<AW)*DW-1:0] mem_flat
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] words [DEPTH];

  // Entries are stored in index order, so a later entry to the same word wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) words[k] <= '0;
    end else if (we) begin
      for (int j = 0; j < NWR; j++) begin
        if (j < clamp_count(int'(wr_cnt), NWR))
          words[wr_addr[j*AW +: AW]] <= wr_data[j*DW +: DW];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) mem_flat[k*DW +: DW] = words[k];
  end

  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem_flat));
endmodule

// File: rtl/tcu_commit_unit.sv
`timescale 1ns/1ps
module tcu_commit_unit import tcu_pkg::*; #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int NSLOT = 4,
  parameter int NRD   = 4,
  parameter int NWR   = 4,
  parameter int TW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [TW-1:0]        req_tag,
  input  logic [$clog2(NRD+1)-1:0] req_rd_cnt,
  input  logic [NRD*AW-1:0]    req_rd_addr,
  input  logic [NRD*DW-1:0]    req_rd_data,
  input  logic [$clog2(NWR+1)-1:0] req_wr_cnt,
  input  logic [NWR*AW-1:0]    req_wr_addr,
  input  logic [NWR*DW-1:0]    req_wr_data,
  output logic                 resp_valid,
  input  logic                 resp_ready,
  output logic [TW-1:0]        resp_tag,
  output logic                 resp_commit
);
  localparam int RCW  = $clog2(NRD+1);
  localparam int WCW  = $clog2(NWR+1);
  localparam int PW   = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int NCW  = $clog2(NSLOT+1);
  localparam int MEMW = (1 << AW) * DW;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (int'(p) == NSLOT-1) ? '0 : p + 1'b1;
  endfunction

  // Slot storage, in arrival order between head and tail.
  slot_state_t         st      [NSLOT];
  logic [TW-1:0]       s_tag   [NSLOT];
  logic [RCW-1:0]      s_rcnt  [NSLOT];
  logic [NRD*AW-1:0]   s_raddr [NSLOT];
  logic [NRD*DW-1:0]   s_rdata [NSLOT];
  logic [WCW-1:0]      s_wcnt  [NSLOT];
  logic [NWR*AW-1:0]   s_waddr [NSLOT];
  logic [NWR*DW-1:0]   s_wdata [NSLOT];
  logic                s_spec  [NSLOT];
  logic [PW-1:0]       head, tail;
  logic [NCW-1:0]      occ;

  // Stage events, named for the assertions.
  logic             acc_fire;      // log transfer with speculative check
  logic             spec_ok;
  logic             haz_hit;       // hazard against older queued writers
  logic             head_stalled;  // head waited on an older writer
  logic             final_ok;      // check of head against current memory
  logic             fin_fire;      // head outcome decided this cycle
  logic             fin_outcome;
  logic             commit_we;     // write log applied to memory
  logic [MEMW-1:0]  mem_flat;

  logic [NSLOT-1:0]        slot_busy;
  logic [NSLOT*WCW-1:0]    slot_wcnt_flat;
  logic [NSLOT*NWR*AW-1:0] slot_waddr_flat;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_flat
      assign slot_busy[s] = (st[s] != SLOT_FREE);
      assign slot_wcnt_flat[s*WCW +: WCW] = s_wcnt[s];
      assign slot_waddr_flat[s*NWR*AW +: NWR*AW] = s_waddr[s];
    end
  endgenerate

  assign req_ready = (occ != NCW'(NSLOT));
  assign acc_fire  = req_valid && req_ready;

  tcu_log_check #(.AW(AW), .DW(DW), .NENT(NRD), .CW(RCW)) u_spec (
    .cnt(req_rd_cnt), .addr(req_rd_addr), .data(req_rd_data),
    .mem_flat(mem_flat), .all_match(spec_ok));

  tcu_hazard #(.AW(AW), .NRD(NRD), .NWR(NWR), .NSLOT(NSLOT), .RCW(RCW), .WCW(WCW)) u_haz (
    .rd_cnt(req_rd_cnt), .rd_addr(req_rd_addr), .slot_busy(slot_busy),
    .slot_wcnt(slot_wcnt_flat), .slot_waddr(slot_waddr_flat), .hit(haz_hit));

  tcu_log_check #(.AW(AW), .DW(DW), .NENT(NRD), .CW(RCW)) u_final (
    .cnt(s_rcnt[head]), .addr(s_raddr[head]), .data(s_rdata[head]),
    .mem_flat(mem_flat), .all_match(final_ok));

  assign head_stalled = (st[head] == SLOT_STALLED);
  assign fin_fire     = (st[head] != SLOT_FREE) && (!resp_valid || resp_ready);
  assign fin_outcome  = head_stalled ? final_ok : s_spec[head];
  assign commit_we    = fin_fire && fin_outcome;

  tcu_word_mem #(.AW(AW), .DW(DW), .NWR(NWR), .WCW(WCW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(commit_we), .wr_cnt(s_wcnt[head]),
    .wr_addr(s_waddr[head]), .wr_data(s_wdata[head]), .mem_flat(mem_flat));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        st[s]      <= SLOT_FREE;
        s_tag[s]   <= '0;
        s_rcnt[s]  <= '0;
        s_raddr[s] <= '0;
        s_rdata[s] <= '0;
        s_wcnt[s]  <= '0;
        s_waddr[s] <= '0;
        s_wdata[s] <= '0;
        s_spec[s]  <= 1'b0;
      end
      head        <= '0;
      tail        <= '0;
      occ         <= '0;
      resp_valid  <= 1'b0;
      resp_tag    <= '0;
      resp_commit <= 1'b0;
    end else begin
      if (acc_fire) begin
        st[tail]      <= haz_hit ? SLOT_STALLED : SLOT_CLEAR;
        s_tag[tail]   <= req_tag;
        s_rcnt[tail]  <= req_rd_cnt;
        s_raddr[tail] <= req_rd_addr;
        s_rdata[tail] <= req_rd_data;
        s_wcnt[tail]  <= req_wr_cnt;
        s_waddr[tail] <= req_wr_addr;
        s_wdata[tail] <= req_wr_data;
        s_spec[tail]  <= spec_ok;
        tail          <= ptr_next(tail);
      end
      if (fin_fire) begin
        st[head]    <= SLOT_FREE;
        head        <= ptr_next(head);
        resp_valid  <= 1'b1;
        resp_tag    <= s_tag[head];
        resp_commit <= fin_outcome;
      end else if (resp_ready) begin
        resp_valid  <= 1'b0;
      end
      occ <= occ + NCW'(acc_fire) - NCW'(fin_fire);
    end
  end

  assert_tail_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> (st[tail] == SLOT_FREE));
  assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= NCW'(NSLOT));
  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_tag) && $stable(resp_commit)));
  assert_resp_from_fin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(fin_fire));
  assert_spec_agrees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_fire && !head_stalled) |-> (final_ok == s_spec[head]));
endmodule

// File: tb/sim_tcu_commit_unit.sv
`timescale 1ns/1ps
module sim_tcu_commit_unit;
  localparam int AW = 4, DW = 8, NS = 4, NR = 4, NW = 4, TW = 4;
  localparam int RCW = 3, WCW = 3, MAXT = 600;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, req_ready, resp_valid, resp_ready, resp_commit;
  logic [TW-1:0] req_tag, resp_tag;
  logic [RCW-1:0] req_rd_cnt;
  logic [WCW-1:0] req_wr_cnt;
  logic [NR*AW-1:0] req_rd_addr;
  logic [NR*DW-1:0] req_rd_data;
  logic [NW*AW-1:0] req_wr_addr;
  logic [NW*DW-1:0] req_wr_data;

  tcu_commit_unit #(.AW(AW), .DW(DW), .NSLOT(NS), .NRD(NR), .NWR(NW), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .req_rd_cnt(req_rd_cnt), .req_rd_addr(req_rd_addr),
    .req_rd_data(req_rd_data), .req_wr_cnt(req_wr_cnt), .req_wr_addr(req_wr_addr),
    .req_wr_data(req_wr_data), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_tag(resp_tag), .resp_commit(resp_commit));

  int t_rc[MAXT], t_wc[MAXT], t_exp[MAXT];
  int t_ra[MAXT][NR], t_rd[MAXT][NR], t_wa[MAXT][NW], t_wd[MAXT][NW];
  string t_lbl[MAXT];
  int c_rc, c_wc;
  int c_ra[NR], c_rd[NR], c_wa[NW], c_wd[NW];
  int mdl[16];
  int n_sent = 0, n_resp = 0, checks = 0, fails = 0;
  int rdy_mode = 1;
  bit done = 1'b0;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // Serial model: outcome of transaction idx against memory after all earlier ones.
  function automatic int model_ok(input int idx);
    int rc;
    rc = (t_rc[idx] > NR) ? NR : t_rc[idx];
    for (int i = 0; i < rc; i++)
      if (mdl[t_ra[idx][i]] != t_rd[idx][i]) return 0;
    return 1;
  endfunction

  task automatic model_apply(input int idx);
    int wc;
    wc = (t_wc[idx] > NW) ? NW : t_wc[idx];
    for (int j = 0; j < wc; j++) mdl[t_wa[idx][j]] = t_wd[idx][j];
  endtask

  task automatic clear_cur();
    c_rc = 0; c_wc = 0;
    for (int i = 0; i < NR; i++) begin c_ra[i] = 0; c_rd[i] = 0; end
    for (int j = 0; j < NW; j++) begin c_wa[j] = 0; c_wd[j] = 0; end
  endtask

  task automatic push(input int exp, input string lbl);
    req_tag    = TW'(n_sent);
    req_rd_cnt = RCW'(c_rc);
    req_wr_cnt = WCW'(c_wc);
    for (int i = 0; i < NR; i++) begin
      req_rd_addr[i*AW +: AW] = AW'(c_ra[i]);
      req_rd_data[i*DW +: DW] = DW'(c_rd[i]);
      t_ra[n_sent][i] = c_ra[i]; t_rd[n_sent][i] = c_rd[i];
    end
    for (int j = 0; j < NW; j++) begin
      req_wr_addr[j*AW +: AW] = AW'(c_wa[j]);
      req_wr_data[j*DW +: DW] = DW'(c_wd[j]);
      t_wa[n_sent][j] = c_wa[j]; t_wd[n_sent][j] = c_wd[j];
    end
    t_rc[n_sent] = c_rc; t_wc[n_sent] = c_wc;
    t_exp[n_sent] = exp; t_lbl[n_sent] = lbl;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    n_sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (n_resp != n_sent) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_mode(input int m);
    rdy_mode = m;
    @(negedge clk);
  endtask

  // Response monitor: ready is chosen first, then a handshake seen here completes at the next edge.
  always @(negedge clk) begin
    int exp_ok;
    if (!rst_n) resp_ready = 1'b0;
    else begin
      case (rdy_mode)
        0: resp_ready = (($urandom % 4) != 0);
        1: resp_ready = 1'b1;
        default: resp_ready = 1'b0;
      endcase
      if (resp_valid && resp_ready) begin
        if (n_resp >= n_sent) chk("R6 response without request", 1, 0);
        else begin
          exp_ok = model_ok(n_resp);
          chk("R6 tag in arrival order", int'(resp_tag), n_resp % 16);
          chk("R2 outcome matches serial model", int'(resp_commit), exp_ok);
          if (t_exp[n_resp] >= 0) chk(t_lbl[n_resp], int'(resp_commit), t_exp[n_resp]);
          if (exp_ok != 0) model_apply(n_resp);
          n_resp++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_resp, n_sent);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int hold_tag, hold_commit;
    void'($urandom(32'd20240607));
    for (int k = 0; k < 16; k++) mdl[k] = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_tag = '0;
    req_rd_cnt = '0; req_wr_cnt = '0;
    req_rd_addr = '0; req_rd_data = '0; req_wr_addr = '0; req_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 resp_valid after reset", int'(resp_valid), 0);
    chk("R1 req_ready after reset", int'(req_ready), 1);

    // R1: every word reads as zero.
    for (int b = 0; b < 4; b++) begin
      clear_cur(); c_rc = 4;
      for (int i = 0; i < NR; i++) c_ra[i] = b*4 + i;
      push(1, "R1 memory zero after reset");
    end
    drain();

    // R10 latency and R3 commit.
    clear_cur(); c_wc = 1; c_wa[0] = 2; c_wd[0] = 'h5A;
    push(1, "R3 write-only commit");
    chk("R10 no response on accept edge", int'(resp_valid), 0);
    @(negedge clk);
    chk("R10 response one edge after accept", int'(resp_valid), 1);
    drain();
    clear_cur(); c_rc = 1; c_ra[0] = 2; c_rd[0] = 'h5A;
    push(1, "R3 committed value stored");
    clear_cur(); c_rc = 1; c_ra[0] = 0; c_rd[0] = 'h99; c_wc = 1; c_wa[0] = 7; c_wd[0] = 'h77;
    push(0, "R3 stale read aborts");
    clear_cur(); c_rc = 1; c_ra[0] = 7; c_rd[0] = 0;
    push(1, "R3 aborted write left word unchanged");

    // R4: repeated write address.
    clear_cur(); c_wc = 2; c_wa[0] = 3; c_wd[0] = 'hAA; c_wa[1] = 3; c_wd[1] = 'hBB;
    push(1, "R4 repeated write commit");
    clear_cur(); c_rc = 1; c_ra[0] = 3; c_rd[0] = 'hBB;
    push(1, "R4 higher index wins");

    // R5: counts and inactive entries.
    clear_cur(); c_rc = 7;
    c_ra[0] = 2; c_rd[0] = 'h5A; c_ra[1] = 3; c_rd[1] = 'hBB; c_ra[2] = 0; c_ra[3] = 1;
    push(1, "R5 read count above limit");
    clear_cur(); c_ra[0] = 2; c_rd[0] = 1;
    push(1, "R5 empty read log passes");
    clear_cur(); c_wc = 1; c_wa[0] = 5; c_wd[0] = 'h55; c_wa[1] = 4; c_wd[1] = 'h44;
    push(1, "R5 one active write");
    clear_cur(); c_rc = 2; c_ra[0] = 4; c_rd[0] = 0; c_ra[1] = 5; c_rd[1] = 'h55;
    push(1, "R5 entry past count ignored");
    clear_cur(); c_wc = 6;
    for (int j = 0; j < NW; j++) begin c_wa[j] = 8 + j; c_wd[j] = j + 1; end
    push(1, "R5 write count above limit");
    clear_cur(); c_rc = 4;
    for (int i = 0; i < NR; i++) begin c_ra[i] = 8 + i; c_rd[i] = i + 1; end
    push(1, "R5 all clamped writes stored");
    drain();

    // R9: held response stays stable.
    set_mode(2);
    clear_cur();
    push(1, "R9 held transaction");
    repeat (2) @(negedge clk);
    chk("R9 response pending", int'(resp_valid), 1);
    hold_tag = int'(resp_tag); hold_commit = int'(resp_commit);
    repeat (3) @(negedge clk);
    chk("R9 response still pending", int'(resp_valid), 1);
    chk("R9 tag stable", int'(resp_tag), hold_tag);
    chk("R9 outcome stable", int'(resp_commit), hold_commit);

    // R8: fill all slots behind the held response.
    for (int k = 0; k < NS; k++) begin clear_cur(); push(1, "R8 filler"); end
    chk("R8 not ready when full", int'(req_ready), 0);
    repeat (3) @(negedge clk);
    chk("R8 still not ready", int'(req_ready), 0);
    rdy_mode = 1;
    repeat (3) @(negedge clk);
    chk("R8 ready after finalize", int'(req_ready), 1);
    drain();

    // R7: stalled readers behind a committing writer.
    clear_cur(); c_wc = 1; c_wa[0] = 9; c_wd[0] = 'h11;
    push(1, "R7 setup write");
    drain();
    set_mode(2);
    clear_cur(); push(1, "R7 blocker");
    clear_cur(); c_rc = 1; c_ra[0] = 9; c_rd[0] = 'h11; c_wc = 1; c_wa[0] = 9; c_wd[0] = 'h22;
    push(1, "R7 older writer commits");
    clear_cur(); c_rc = 1; c_ra[0] = 9; c_rd[0] = 'h22; c_wc = 1; c_wa[0] = 10; c_wd[0] = 'h33;
    push(1, "R7 reader of new value commits");
    clear_cur(); c_rc = 1; c_ra[0] = 9; c_rd[0] = 'h11; c_wc = 1; c_wa[0] = 10; c_wd[0] = 'h44;
    push(0, "R7 reader of old value aborts");
    set_mode(1);
    drain();
    clear_cur(); c_rc = 1; c_ra[0] = 10; c_rd[0] = 'h33;
    push(1, "R7 aborted reader left word unchanged");
    drain();

    // R7: stalled reader behind an aborting writer.
    set_mode(2);
    clear_cur(); push(1, "R7 blocker");
    clear_cur(); c_rc = 1; c_ra[0] = 9; c_rd[0] = 'h55; c_wc = 1; c_wa[0] = 9; c_wd[0] = 'h66;
    push(0, "R7 older writer aborts");
    clear_cur(); c_rc = 1; c_ra[0] = 9; c_rd[0] = 'h22;
    push(1, "R7 reader commits after older abort");
    set_mode(1);
    drain();

    // Random stream over hot addresses.
    rdy_mode = 0;
    for (int n = 0; n < 400; n++) begin
      clear_cur();
      c_rc = (($urandom % 10) == 0) ? 5 + ($urandom % 3) : $urandom % 5;
      c_wc = (($urandom % 10) == 0) ? 5 + ($urandom % 3) : $urandom % 5;
      for (int i = 0; i < NR; i++) begin
        c_ra[i] = $urandom % 8;
        c_rd[i] = (($urandom % 4) != 0) ? mdl[c_ra[i]] : $urandom % 256;
      end
      for (int j = 0; j < NW; j++) begin
        c_wa[j] = $urandom % 8;
        c_wd[j] = $urandom % 256;
      end
      push(-1, "R2 random");
      if (($urandom % 5) == 0) @(negedge clk);
    end
    set_mode(1);
    drain();
    chk("R6 all responses received", n_resp, n_sent);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule